// File: doc/BRIEF.md
# Multiplexed-Address DRAM Core

This block is a synthesizable behavioural model of a small dynamic memory device. The device has an asynchronous-style strobe interface, and a fast system clock samples every pin of that interface. Three active-low strobes control the device: a row strobe, a column strobe and a write strobe. One address bus carries the row number first and the column number later. The data input and the data output are separate single-bit pins. The storage is organised as 2^ROW_W rows of 2^COL_W bits.

When the row strobe falls, a whole row is copied into a row buffer. Column strobes then read bits from the buffer or write bits into it. When the row strobe rises, the buffer is stored back into the row it came from.

The block supports these access and refresh forms:
- Page accesses, where many column cycles hit the same open row.
- Four-bit nibble bursts, where each further column pulse steps to the next column.
- Refresh by a row cycle with no column cycle.
- Column-before-row refresh, where an internal counter supplies the row.

An error pulse flags a column access that arrives too soon after the row was opened.

Top module: `dram_core`

## Requirements
- R1: During reset and after it, dout, dout_valid and proto_err are 0 and ref_row is 0.
- R2: The first clock sample in which ras_n is 0 (after a sample with ras_n at 1) latches addr as the row number and copies that row into the buffer. Later changes on addr do not change which row is open.
- R3: While a row is open, the first sample with cas_n at 0 and we_n at 1 is a read. On the next cycle dout_valid is 1 and dout holds the buffer bit of the latched column (addr[COL_W-1:0]).
- R4: A column strobe that falls with we_n at 0 stores din into the selected buffer bit. dout_valid stays 0 for that column cycle.
- R5: The first sample with cas_n back at 1, or with ras_n back at 1, makes dout_valid 0 and dout 0 on the next cycle.
- R6: When ras_n returns to 1, the buffer is stored back into the open row. Data written during a row cycle is therefore returned by every later row cycle to that row.
- R7: If cas_n is already 0 in the sample where ras_n falls, the row comes from the refresh counter ref_row and not from addr. The row's data is unchanged, dout_valid stays 0 for the whole cycle, and ref_row advances by one (modulo 2^ROW_W) when ras_n rises.
- R8: A row cycle with no column strobe leaves the data of the row unchanged and never makes dout_valid 1.
- R9: With nibble_en at 1 in the sample where ras_n falls, the first column strobe latches addr. Each later column strobe in the same row cycle ignores addr and uses the next column in the aligned group of four, so the low two column bits wrap from 3 to 0 and the upper bits stay the same.
- R10: With nibble_en at 0, every column strobe in one row cycle latches its own column from addr and reads or writes it.
- R11: proto_err is 1 for exactly one cycle after a column access whose column strobe falls fewer than MIN_RAS_TO_CAS clock samples (default 3) after the row strobe fell. The access itself is still performed.
- R12: A column strobe that falls while ras_n is 1 and no row is open performs no access and leaves dout_valid at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low, sampled when the column strobe falls |
| addr | input | ADDR_W | Shared row/column address |
| din | input | 1 | Write data |
| nibble_en | input | 1 | Burst mode select, sampled when the row strobe falls |
| dout | output | 1 | Read data |
| dout_valid | output | 1 | Read data is driven |
| proto_err | output | 1 | One-cycle pulse for a column access that came too early |
| ref_row | output | ROW_W | Row the next column-before-row refresh will use |

## Verification
The bench targets the cases where a simpler model would still look right:
- It writes in one row cycle and reads in a later one, so a design that never stores the buffer back returns stale zeros.
- It starts nibble bursts at columns 2 and 3 and scrambles addr on the later pulses. A design without wrap, or one that follows addr, reads the wrong neighbour bit.
- It runs seventeen counter-driven refreshes, so a counter that does not advance, or does not wrap, shows on ref_row.
- It opens a row with a one-cycle gap before the column strobe, so a design without the timing check stays silent.
- It pulses the column strobe while no row is open, so a design that enables the output there is caught.

// File: rtl/dram_pkg.sv
package dram_pkg;

  // Strobes issued by the control unit to the storage datapath, one cycle wide.
  typedef struct packed {
    logic loadRow;    // copy array row into buffer
    logic writeBack;  // store buffer into array row
    logic colStrobe;  // a column access happens this cycle
    logic writeBit;   // buffer bit takes din
    logic readBit;    // buffer bit goes to the output
    logic dropOut;    // output returns to disabled
  } dramStrobe_t;

endpackage

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int MIN_RAS_TO_CAS = 3,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              nibbleEn,
  output dramStrobe_t       strobes,
  output logic [ROW_W-1:0]  rowSel,
  output logic [COL_W-1:0]  colSel,
  output logic              rowOpen,
  output logic              cbrActive,
  output logic              protoErr,
  output logic [ROW_W-1:0]  refRow
);

  localparam int AGE_W = $clog2(MIN_RAS_TO_CAS + 1) + 1;

  logic rasPrev, casPrev;
  logic nibbleMode, firstCasSeen;
  logic [ROW_W-1:0] rowReg, refCnt;
  logic [COL_W-1:0] colReg, colNext, colStep;
  logic [AGE_W-1:0] rasAge;

  logic rasFall, rasRise, casFall, casRise, accessFall, tooEarly;

  assign rasFall    = rasPrev && !rasN;
  assign rasRise    = !rasPrev && rasN;
  assign casFall    = casPrev && !casN;
  assign casRise    = !casPrev && casN;
  assign accessFall = casFall && rowOpen && !cbrActive && !rasN;
  assign tooEarly   = (32'(rasAge) + 32'd1) < 32'(MIN_RAS_TO_CAS);

  // Next column inside an aligned group of four.
  generate
    if (COL_W == 2) begin : g_nib_narrow
      assign colStep = colReg + 2'd1;
    end else begin : g_nib_wide
      assign colStep = {colReg[COL_W-1:2], colReg[1:0] + 2'd1};
    end
  endgenerate

  always_comb begin
    if (nibbleMode && firstCasSeen) colNext = colStep;
    else                            colNext = addr[COL_W-1:0];
  end

  always_comb begin
    strobes.loadRow   = rasFall;
    strobes.writeBack = rasRise && rowOpen;
    strobes.colStrobe = accessFall;
    strobes.writeBit  = accessFall && !weN;
    strobes.readBit   = accessFall && weN;
    strobes.dropOut   = casRise || rasRise;
  end

  always_comb begin
    if (rasFall) rowSel = casN ? addr[ROW_W-1:0] : refCnt;
    else         rowSel = rowReg;
  end

  assign colSel = colNext;
  assign refRow = refCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rasPrev      <= 1'b1;
      casPrev      <= 1'b1;
      rowOpen      <= 1'b0;
      cbrActive    <= 1'b0;
      nibbleMode   <= 1'b0;
      firstCasSeen <= 1'b0;
      rowReg       <= '0;
      colReg       <= '0;
      refCnt       <= '0;
      rasAge       <= '0;
      protoErr     <= 1'b0;
    end else begin
      rasPrev  <= rasN;
      casPrev  <= casN;
      protoErr <= accessFall && tooEarly;
      if (rasFall) begin
        rowOpen      <= 1'b1;
        cbrActive    <= !casN;
        rowReg       <= rowSel;
        nibbleMode   <= nibbleEn;
        firstCasSeen <= 1'b0;
        rasAge       <= '0;
      end else if (rasRise) begin
        rowOpen   <= 1'b0;
        cbrActive <= 1'b0;
        if (cbrActive) refCnt <= refCnt + 1'b1;
      end else if (rowOpen && rasAge != AGE_W'(MIN_RAS_TO_CAS)) begin
        rasAge <= rasAge + 1'b1;
      end
      if (accessFall) begin
        colReg       <= colNext;
        firstCasSeen <= 1'b1;
      end
    end
  end

  initial begin
    assert_param_cols_R9 : assert (COL_W >= 2 && MIN_RAS_TO_CAS >= 1);
  end

  // R7: the refresh counter only moves at the close of a counter-driven cycle.
  assert_refcnt_move_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refCnt) |-> $past(rasRise && cbrActive));

  // R7: no column access is issued inside a counter-driven refresh.
  assert_cbr_no_access_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    cbrActive |-> !strobes.colStrobe);

  // R9: burst steps keep the group and advance the low two bits.
  assert_nibble_step_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (accessFall && nibbleMode && firstCasSeen) |=>
      (colReg[1:0] == $past(colReg[1:0]) + 2'd1) &&
      (colReg[COL_W-1:2] == $past(colReg[COL_W-1:2])));

  // R11: the error pulse follows a column access.
  assert_err_on_cas_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    protoErr |-> $past(accessFall));

endmodule

// File: rtl/dram_datapath.sv
module dram_datapath
  import dram_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  localparam int ROWS = 1 << ROW_W,
  localparam int COLS = 1 << COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dramStrobe_t      strobes,
  input  logic [ROW_W-1:0] rowSel,
  input  logic [COL_W-1:0] colSel,
  input  logic             din,
  output logic             dout,
  output logic             doutValid
);

  logic [COLS-1:0] memRow [ROWS];
  logic [COLS-1:0] rowBuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) memRow[r] <= '0;
    end else if (strobes.writeBack) begin
      memRow[rowSel] <= rowBuf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowBuf <= '0;
    end else if (strobes.loadRow) begin
      rowBuf <= memRow[rowSel];
    end else if (strobes.writeBit) begin
      rowBuf[colSel] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= 1'b0;
      doutValid <= 1'b0;
    end else if (strobes.dropOut) begin
      dout      <= 1'b0;
      doutValid <= 1'b0;
    end else if (strobes.readBit) begin
      dout      <= rowBuf[colSel];
      doutValid <= 1'b1;
    end
  end

  // R5: closing either strobe disables the output one cycle later.
  assert_valid_clear_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    strobes.dropOut |=> !doutValid);

  // R4: a write cycle never enables the output.
  assert_write_silent_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    strobes.writeBit |=> !doutValid);

endmodule

// File: rtl/dram_core.sv
module dram_core
  import dram_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int MIN_RAS_TO_CAS = 3,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  input  logic              nibble_en,
  output logic              dout,
  output logic              dout_valid,
  output logic              proto_err,
  output logic [ROW_W-1:0]  ref_row
);

  dramStrobe_t      strobes;
  logic [ROW_W-1:0] rowSel;
  logic [COL_W-1:0] colSel;
  logic             rowOpen, cbrActive;

  dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .MIN_RAS_TO_CAS(MIN_RAS_TO_CAS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rasN(ras_n), .casN(cas_n), .weN(we_n),
    .addr(addr), .nibbleEn(nibble_en), .strobes(strobes), .rowSel(rowSel),
    .colSel(colSel), .rowOpen(rowOpen), .cbrActive(cbrActive),
    .protoErr(proto_err), .refRow(ref_row)
  );

  dram_datapath #(.ROW_W(ROW_W), .COL_W(COL_W)) data_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rowSel(rowSel),
    .colSel(colSel), .din(din), .dout(dout), .doutValid(dout_valid)
  );

  // R7: a counter-driven refresh never enables the output.
  assert_cbr_quiet_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    cbrActive |-> !dout_valid);

  // R3 / R12: valid data is only driven while a row is open.
  assert_valid_needs_row_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> rowOpen);

endmodule

// File: tb/dram_core_tb.sv
`timescale 1ns/1ps
module dram_core_tb_top;

  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int MINGAP = 3;
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0, nibble_en = 1'b0;
  logic [3:0] addr = '0;
  logic dout, dout_valid, proto_err;
  logic [ROW_W-1:0] ref_row;

  always #2 clk = ~clk;

  dram_core #(.ROW_W(ROW_W), .COL_W(COL_W), .MIN_RAS_TO_CAS(MINGAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .nibble_en(nibble_en), .dout(dout),
    .dout_valid(dout_valid), .proto_err(proto_err), .ref_row(ref_row)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [COLS-1:0] model [ROWS];
  logic [COLS-1:0] mbuf;
  int curRow, mcol, expRef;
  bit nibMode, firstCas;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextNibble(input int c);
    return (c & ~3) | ((c + 1) & 3);
  endfunction

  // Open a row; gap = clock samples from row strobe to the first column strobe.
  task automatic rasDown(input int row, input bit nib, input int gap);
    addr = 4'(row); nibble_en = nib; ras_n = 1'b0;
    @(negedge clk);
    addr = 4'($urandom);
    repeat (gap - 1) @(negedge clk);
    curRow = row; mbuf = model[row]; nibMode = nib; firstCas = 1;
  endtask

  task automatic casCycle(input int col, input bit wr, input bit d, input bit expErr);
    if (nibMode && !firstCas) begin
      mcol = nextNibble(mcol);
      addr = 4'($urandom);
    end else begin
      mcol = col;
      addr = 4'(col);
    end
    firstCas = 0;
    we_n = !wr; din = d; cas_n = 1'b0;
    @(negedge clk);
    chk("R11 proto_err", proto_err, expErr);
    if (wr) begin
      mbuf[mcol] = d;
      chk("R4 dout_valid on write", dout_valid, 0);
    end else begin
      chk(nibMode ? "R3/R9 dout_valid" : "R3/R10 dout_valid", dout_valid, 1);
      chk(nibMode ? "R9 nibble dout" : "R10 page dout", dout, mbuf[mcol]);
    end
    cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    chk("R5 dout_valid after cas rise", dout_valid, 0);
    chk("R11 no repeat error", proto_err, 0);
  endtask

  task automatic rasUp();
    ras_n = 1'b1;
    @(negedge clk);
    model[curRow] = mbuf;
    @(negedge clk);
  endtask

  task automatic cbrRefresh();
    cas_n = 1'b0;
    @(negedge clk);
    chk("R12 cas without row", dout_valid, 0);
    ras_n = 1'b0; addr = 4'($urandom);
    @(negedge clk);
    repeat (2) begin
      @(negedge clk);
      chk("R7 refresh output off", dout_valid, 0);
    end
    ras_n = 1'b1;
    @(negedge clk);
    cas_n = 1'b1;
    @(negedge clk);
    expRef = (expRef + 1) % ROWS;
    chk("R7 ref_row advance", ref_row, expRef);
  endtask

  task automatic rasOnly(input int row);
    rasDown(row, 0, 1);
    repeat (2) begin
      @(negedge clk);
      chk("R8 row-only output off", dout_valid, 0);
    end
    rasUp();
  endtask

  task automatic readRow(input int row, input string req);
    rasDown(row, 0, MINGAP);
    for (int c = 0; c < COLS; c++) begin
      addr = 4'(c); cas_n = 1'b0;
      @(negedge clk);
      chk(req, dout, model[row][c]);
      cas_n = 1'b1;
      @(negedge clk);
    end
    rasUp();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    expRef = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset dout_valid", dout_valid, 0);
    chk("R1 reset ref_row", ref_row, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset dout", dout, 0);
    chk("R1 after reset proto_err", proto_err, 0);

    // R10 page writes, then reads in the same row cycle.
    rasDown(5, 0, MINGAP);
    for (int c = 0; c < COLS; c++) casCycle(c, 1, 1'((c * 7 + 3) >> 2), 0);
    for (int c = COLS - 1; c >= 0; c--) casCycle(c, 0, 0, 0);
    rasUp();
    // R6 / R2: later row cycle returns stored data, addr scrambled after latch.
    readRow(5, "R6 write-back");
    readRow(6, "R2 other row untouched");

    // R9 nibble bursts starting mid-group.
    rasDown(9, 1, MINGAP);
    casCycle(2, 1, 1, 0); casCycle(0, 1, 0, 0); casCycle(0, 1, 1, 0); casCycle(0, 1, 1, 0);
    rasUp();
    rasDown(9, 1, MINGAP);
    casCycle(3, 0, 0, 0); casCycle(0, 0, 0, 0); casCycle(0, 0, 0, 0); casCycle(0, 0, 0, 0);
    casCycle(0, 0, 0, 0);
    rasUp();

    // R11 column strobe one sample after the row strobe.
    rasDown(5, 0, 1);
    casCycle(4, 0, 0, 1);
    casCycle(5, 0, 0, 0);
    rasUp();
    rasDown(5, 0, MINGAP - 1);
    casCycle(6, 0, 0, 1);
    rasUp();

    // R7 refresh counter across a full wrap; R8 row-only refresh.
    for (int i = 0; i < ROWS + 1; i++) cbrRefresh();
    rasOnly(5);
    readRow(5, "R7/R8 data kept through refresh");
    readRow(9, "R7 data kept through refresh");

    // Random mix.
    for (int it = 0; it < 150; it++) begin
      int op = int'($urandom % 8);
      if (op == 0) cbrRefresh();
      else if (op == 1) rasOnly(int'($urandom % ROWS));
      else begin
        int n = 1 + int'($urandom % 6);
        rasDown(int'($urandom % ROWS), 1'($urandom), MINGAP + int'($urandom % 2));
        for (int k = 0; k < n; k++)
          casCycle(int'($urandom % COLS), 1'($urandom), 1'($urandom), 0);
        rasUp();
      end
    end
    for (int r = 0; r < ROWS; r++) readRow(r, "R6 final array");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule